// File: doc/BRIEF.md
# Lockstep Multi-ADC Capture

This block reads a group of serial analog-to-digital converters in parallel. Every converter hangs on the same serial clock and the same active-low chip-select, and each one returns its result on its own data pin. The block drives the shared clock and select, samples all data pins at the same serial-clock rising edge, and assembles one word per channel. All channels are therefore captured in exact lockstep.

Each frame has three parts. First come a few preparatory clock pulses, issued as soon as the chip-select idle time has passed. Next comes a single conversion-start pulse, which is held back until the external sample-rate strobe arrives. Last come the data pulses. Because the conversion instant is set by the strobe and not by the serial clock, the sampling jitter follows the strobe source only.

When a frame completes, all channel words are presented together with a one-cycle valid pulse. The strobe must be synchronous to `clk`. The data output has no back-pressure: a consumer must take the words in the valid cycle, or at the latest before the first data bit of the next frame. A strobe that comes when the block is not waiting for one sets a sticky overrun flag.

Top module: `lockstep_adc_capture`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `adc_cs_n`=1, `adc_sclk`=0, `samples_valid`=0 and `overrun`=0. A reset in the middle of a frame abandons that frame.
- R2: `adc_cs_n` stays high for at least CS_IDLE_MIN consecutive `clk` cycles before every falling edge, including the first one after reset. `adc_sclk` is 0 whenever `adc_cs_n` is 1.
- R3: After `adc_cs_n` falls, exactly PRE_CLKS (default 4) preparatory pulses are issued without waiting for a strobe. Each pulse is SCLK_HALF cycles high and SCLK_HALF cycles low. `adc_sclk` then stays low until a strobe arrives.
- R4: When the block is waiting after the preparatory pulses, `adc_sclk` is 1 in the cycle right after the first `clk` edge that samples `sample_strobe` high (a rising edge of the strobe). This is the conversion-start pulse, pulse number PRE_CLKS+1.
- R5: The conversion pulse is followed by SAMPLE_W data pulses, for PRE_CLKS+1+SAMPLE_W pulses per frame (29 by default). After the low phase of the last pulse, `adc_cs_n` returns to 1.
- R6: The word for channel c sits in `samples_out[c*SAMPLE_W +: SAMPLE_W]` and is built from `adc_sdata[c]` MSB first. The value on the pin at the `clk` edge where the k-th data pulse (k=0..SAMPLE_W-1) rises lands in bit SAMPLE_W-1-k.
- R7: Values on the data pins during the preparatory and conversion pulses have no effect on any word.
- R8: `samples_valid` is a single-cycle pulse, given once per completed frame. It is high two cycles after the cycle in which the last data pulse first shows high. The words are complete in that cycle and stay unchanged until the next frame's first data bit is captured.
- R9: A rising edge of `sample_strobe` that arrives when the block is not waiting for one (chip-select idle, preparatory or data phase) sets `overrun`, which stays 1 until reset. Such a strobe issues no pulse and does not change the frame. A strobe held high for several cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_strobe | input | 1 | Sample-rate strobe, synchronous to clk; its rising edge starts a conversion |
| adc_sdata | input | NUM_CH | One serial data line per converter |
| adc_sclk | output | 1 | Shared serial clock |
| adc_cs_n | output | 1 | Shared chip-select, active low |
| samples_out | output | NUM_CH*SAMPLE_W | All channel words, channel 0 in the low bits |
| samples_valid | output | 1 | One-cycle pulse when a frame's words are complete |
| overrun | output | 1 | Sticky flag: a strobe came when none was expected |

## Verification
The hardest case to reach from the ports is the split between a strobe that is expected and one that is not. The same pin either launches the conversion pulse on the next cycle or only raises the overrun flag, and which one happens depends on an internal phase that the ports show only indirectly. The stimulus follows the phase through the pulse count on `adc_sclk`. It fires each real strobe a random number of cycles after the fourth preparatory pulse has fully ended, holds one strobe high for several cycles, and places a stray strobe in the middle of a data phase. A converter model drives preamble garbage that is the opposite of the data pattern, so a bit taken during the preamble would show up in the words.

// File: rtl/lac_pkg.sv
`timescale 1ns/1ps
package lac_pkg;

  typedef enum logic [2:0] {
    SEQ_CS_IDLE,
    SEQ_PRE,
    SEQ_ARM,
    SEQ_CONV,
    SEQ_DATA
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_HI,
    PH_LO
  } sclk_phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lac_sclk_gen.sv
`timescale 1ns/1ps
module lac_sclk_gen
  import lac_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic sclk,
  output logic rise,
  output logic ready
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  sclk_phase_e    phase;
  logic [CW-1:0]  cnt;
  logic           last;

  assign last  = (cnt == CW'(HALF - 1));
  assign ready = (phase == PH_OFF) || ((phase == PH_LO) && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OFF;
      cnt   <= '0;
      sclk  <= 1'b0;
      rise  <= 1'b0;
    end else begin
      rise <= 1'b0;
      unique case (phase)
        PH_OFF: begin
          if (go) begin
            phase <= PH_HI;
            cnt   <= '0;
            sclk  <= 1'b1;
            rise  <= 1'b1;
          end
        end
        PH_HI: begin
          if (last) begin
            phase <= PH_LO;
            cnt   <= '0;
            sclk  <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_LO: begin
          if (last) begin
            cnt <= '0;
            if (go) begin
              phase <= PH_HI;
              sclk  <= 1'b1;
              rise  <= 1'b1;
            end else begin
              phase <= PH_OFF;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_OFF;
          cnt   <= '0;
          sclk  <= 1'b0;
        end
      endcase
    end
  end

  // R5
  go_ready_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> ready);

  // R3
  rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> (sclk && !$past(sclk)));

  // R3
  hi_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> ($past(phase) == PH_HI));

endmodule

// File: rtl/lac_sync_bank.sv
`timescale 1ns/1ps
module lac_sync_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= din[g];
        stable_q <= meta_q;
      end
    end
    assign dout[g] = stable_q;
  end

endmodule

// File: rtl/lac_shift_bank.sv
`timescale 1ns/1ps
module lac_shift_bank #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift_en,
  input  logic [NUM_CH-1:0]            bits,
  output logic [NUM_CH*SAMPLE_W-1:0]   words,
  output logic                         word_valid
);

  localparam int BCW = $clog2(SAMPLE_W + 1);

  logic [BCW-1:0] bit_cnt;
  logic           last_bit;

  assign last_bit = (bit_cnt == BCW'(SAMPLE_W - 1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SAMPLE_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (shift_en) begin
        word_q <= {word_q[SAMPLE_W-2:0], bits[c]};
      end
    end
    assign words[c*SAMPLE_W +: SAMPLE_W] = word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= shift_en && last_bit;
      if (shift_en) begin
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  // R8
  valid_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(shift_en));

  // R8
  words_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(shift_en) |-> $stable(words));

endmodule

// File: rtl/lac_sequencer.sv
`timescale 1ns/1ps
module lac_sequencer
  import lac_pkg::*;
#(
  parameter int PRE_CLKS    = 4,
  parameter int SAMPLE_W    = 24,
  parameter int CS_IDLE_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic gen_ready,
  input  logic gen_rise,
  output logic go,
  output logic cs_n,
  output logic take_bit,
  output logic overrun
);

  localparam int MAXC = max3(PRE_CLKS, SAMPLE_W, CS_IDLE_MIN);
  localparam int CW   = $clog2(MAXC + 1) + 1;

  seq_state_e     state;
  logic [CW-1:0]  cnt;
  logic           strobe_q;
  logic           strobe_edge;

  assign strobe_edge = strobe && !strobe_q;
  assign take_bit    = gen_rise && (state == SEQ_DATA);

  always_comb begin
    go = 1'b0;
    unique case (state)
      SEQ_PRE:  go = gen_ready && (cnt < CW'(PRE_CLKS));
      SEQ_ARM:  go = strobe_edge;
      SEQ_CONV: go = gen_ready;
      SEQ_DATA: go = gen_ready && (cnt < CW'(SAMPLE_W));
      default:  go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_CS_IDLE;
      cnt      <= '0;
      cs_n     <= 1'b1;
      strobe_q <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (strobe_edge && (state != SEQ_ARM)) begin
        overrun <= 1'b1;
      end
      unique case (state)
        SEQ_CS_IDLE: begin
          if (cnt >= CW'(CS_IDLE_MIN - 1)) begin
            state <= SEQ_PRE;
            cnt   <= '0;
            cs_n  <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_PRE: begin
          if (go) begin
            cnt <= cnt + 1'b1;
          end else if (gen_ready) begin
            state <= SEQ_ARM;
            cnt   <= '0;
          end
        end
        SEQ_ARM: begin
          if (strobe_edge) begin
            state <= SEQ_CONV;
          end
        end
        SEQ_CONV: begin
          if (gen_ready) begin
            state <= SEQ_DATA;
            cnt   <= CW'(1);
          end
        end
        SEQ_DATA: begin
          if (go) begin
            cnt <= cnt + 1'b1;
          end else if (gen_ready) begin
            state <= SEQ_CS_IDLE;
            cnt   <= '0;
            cs_n  <= 1'b1;
          end
        end
        default: begin
          state <= SEQ_CS_IDLE;
          cnt   <= '0;
          cs_n  <= 1'b1;
        end
      endcase
    end
  end

  // R4
  arm_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ARM && strobe_edge) |=> gen_rise);

  // R3
  arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ARM && !strobe_edge) |=> !gen_rise);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R7
  take_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    take_bit |-> !cs_n);

endmodule

// File: rtl/lockstep_adc_capture.sv
`timescale 1ns/1ps
module lockstep_adc_capture #(
  parameter int NUM_CH      = 8,
  parameter int SAMPLE_W    = 24,
  parameter int SCLK_HALF   = 4,
  parameter int PRE_CLKS    = 4,
  parameter int CS_IDLE_MIN = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sample_strobe,
  input  logic [NUM_CH-1:0]          adc_sdata,
  output logic                       adc_sclk,
  output logic                       adc_cs_n,
  output logic [NUM_CH*SAMPLE_W-1:0] samples_out,
  output logic                       samples_valid,
  output logic                       overrun
);

  localparam int HCW = $clog2(CS_IDLE_MIN + 1) + 1;

  logic              gen_go;
  logic              gen_rise;
  logic              gen_ready;
  logic              take_bit;
  logic              take_d1;
  logic [NUM_CH-1:0] data_sync;

  lac_sclk_gen #(.HALF(SCLK_HALF)) u_clkgen (
    .clk   (clk),
    .rst   (rst),
    .go    (gen_go),
    .sclk  (adc_sclk),
    .rise  (gen_rise),
    .ready (gen_ready)
  );

  lac_sequencer #(
    .PRE_CLKS    (PRE_CLKS),
    .SAMPLE_W    (SAMPLE_W),
    .CS_IDLE_MIN (CS_IDLE_MIN)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .strobe    (sample_strobe),
    .gen_ready (gen_ready),
    .gen_rise  (gen_rise),
    .go        (gen_go),
    .cs_n      (adc_cs_n),
    .take_bit  (take_bit),
    .overrun   (overrun)
  );

  lac_sync_bank #(.WIDTH(NUM_CH)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (adc_sdata),
    .dout (data_sync)
  );

  // the synchroniser adds two stages; the take tag waits one more so the
  // shift uses the value the pins held at the rising serial edge
  always_ff @(posedge clk) begin
    if (rst) take_d1 <= 1'b0;
    else     take_d1 <= take_bit;
  end

  lac_shift_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (take_d1),
    .bits       (data_sync),
    .words      (samples_out),
    .word_valid (samples_valid)
  );

  // checker state: cycles spent with chip-select high
  logic [HCW-1:0] cs_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hi_cnt <= '0;
    end else if (!adc_cs_n) begin
      cs_hi_cnt <= '0;
    end else if (cs_hi_cnt < HCW'(CS_IDLE_MIN)) begin
      cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end
  end

  // R2
  cs_idle_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> (cs_hi_cnt >= HCW'(CS_IDLE_MIN)));

  // R2
  cs_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_sclk);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    samples_valid |=> !samples_valid);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (adc_cs_n && !adc_sclk && !samples_valid && !overrun));

endmodule

// File: tb/lockstep_adc_capture_bench.sv
`timescale 1ns/1ps
module lockstep_adc_capture_bench;

  localparam int NCH    = 8;
  localparam int SW     = 24;
  localparam int HALF   = 4;
  localparam int PRE    = 4;
  localparam int IDLE   = 4;
  localparam int PULSES = PRE + 1 + SW;
  localparam int NFR    = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              strobe = 1'b0;
  logic [NCH-1:0]    sdata = '0;
  logic              sclk;
  logic              cs_n;
  logic [NCH*SW-1:0] words;
  logic              valid;
  logic              ovr;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;

  int     mode = 0;
  bit     exp_ovr = 1'b0;
  logic [SW-1:0] exp_w [NCH];
  int     rise_cnt = 0;
  int     fall_cnt = 0;
  int     hi_run = 0;
  int     valid_cnt = 0;
  longint last_rise_cyc = 0;
  bit     sclk_bad = 1'b0;
  bit     prev_sclk = 1'b0;
  bit     prev_cs = 1'b1;
  bit     prev_valid = 1'b0;

  always #4 clk = ~clk;

  lockstep_adc_capture #(
    .NUM_CH(NCH), .SAMPLE_W(SW), .SCLK_HALF(HALF),
    .PRE_CLKS(PRE), .CS_IDLE_MIN(IDLE)
  ) u_lockstep_adc_capture (
    .clk           (clk),
    .rst           (rst),
    .sample_strobe (strobe),
    .adc_sdata     (sdata),
    .adc_sclk      (sclk),
    .adc_cs_n      (cs_n),
    .samples_out   (words),
    .samples_valid (valid),
    .overrun       (ovr)
  );

  function automatic logic [SW-1:0] make_word(input int m, input int ch);
    logic [31:0] r;
    case (m)
      0: return '1;
      1: return '0;
      2: return (ch % 2 == 0) ? SW'(24'hAAAAAA) : SW'(24'h555555);
      default: begin
        r = $urandom;
        return r[SW-1:0];
      end
    endcase
  endfunction

  function automatic logic [NCH-1:0] garbage(input int m);
    logic [31:0] r;
    r = $urandom;
    if (m == 0) return '0;
    if (m == 1) return '1;
    return r[NCH-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // converter model and frame monitor
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_sclk = 1'b0;
      prev_cs   = 1'b1;
      rise_cnt  = 0;
      fall_cnt  = 0;
      hi_run    = 0;
      sclk_bad  = 1'b0;
      prev_valid = 1'b0;
    end else begin
      if (prev_cs && !cs_n) begin
        check(hi_run >= IDLE && !sclk_bad, "R2", "cs idle cycles",
              hi_run, IDLE);
        hi_run = 0; sclk_bad = 1'b0;
        rise_cnt = 0; fall_cnt = 0; valid_cnt = 0;
        for (int c = 0; c < NCH; c++) exp_w[c] = make_word(mode, c);
        sdata = garbage(mode);
      end
      if (cs_n) begin
        hi_run++;
        if (sclk) sclk_bad = 1'b1;
      end
      if (!prev_cs && cs_n) begin
        check(rise_cnt == PULSES, "R5", "pulses per frame", rise_cnt, PULSES);
        check(valid_cnt == 1, "R8", "valid pulses per frame", valid_cnt, 1);
        check(ovr == exp_ovr, "R9", "overrun at frame end", ovr, exp_ovr);
      end
      if (sclk && !prev_sclk) begin
        rise_cnt++;
        last_rise_cyc = cyc;
      end
      if (!sclk && prev_sclk) begin
        fall_cnt++;
        if (fall_cnt >= PRE + 1 && fall_cnt <= PRE + SW) begin
          for (int c = 0; c < NCH; c++)
            sdata[c] = exp_w[c][SW-1-(fall_cnt-PRE-1)];
        end else begin
          sdata = garbage(mode);
        end
      end
      if (valid) begin
        valid_cnt++;
        check(rise_cnt == PULSES && (cyc - last_rise_cyc) == 2, "R8",
              "valid latency after last rise", cyc - last_rise_cyc, 2);
        for (int c = 0; c < NCH; c++) begin
          check(words[c*SW +: SW] == exp_w[c], (mode < 2) ? "R7" : "R6",
                $sformatf("word ch%0d", c), words[c*SW +: SW], exp_w[c]);
        end
        check(!prev_valid, "R8", "valid single cycle", prev_valid, 0);
      end
      prev_sclk  = sclk;
      prev_cs    = cs_n;
      prev_valid = valid;
    end
  end

  task automatic wait_armed();
    while (!(rise_cnt == PRE && !cs_n)) @(negedge clk);
    repeat (2*HALF + 1 + ($urandom % 50)) @(negedge clk);
    check(sclk == 1'b0 && cs_n == 1'b0 && rise_cnt == PRE, "R3",
          "waiting after preamble", rise_cnt, PRE);
  endtask

  task automatic fire(input int hold);
    strobe = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R4", "conversion pulse after strobe", sclk, 1);
    repeat (hold - 1) @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check(cs_n && !sclk && !valid && !ovr, "R1", "state during reset",
          {cs_n, sclk, valid, ovr}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !valid && !ovr, "R1", "state after reset",
          {cs_n, sclk, valid, ovr}, 4'b1000);

    for (int fr = 0; fr < NFR; fr++) begin
      wait_armed();
      fire((fr == 4) ? 3 : 1);
      if (fr == 4) begin
        @(negedge clk);
        check(ovr == 1'b0, "R9", "held strobe counted once", ovr, 0);
      end
      if (fr == 8) begin
        check(ovr == 1'b0, "R9", "no overrun before stray", ovr, 0);
        repeat (60) @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        exp_ovr = 1'b1;
        @(negedge clk);
        check(ovr == 1'b1, "R9", "stray strobe sets overrun", ovr, 1);
      end
      while (!cs_n) @(negedge clk);
      mode = (fr + 1 < 3) ? fr + 1 : 3;
    end

    // reset in the middle of a data phase
    wait_armed();
    fire(1);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && !sclk && !valid, "R1", "mid-frame reset outputs",
          {cs_n, sclk, valid}, 3'b100);
    rst = 1'b0;
    exp_ovr = 1'b0;
    @(negedge clk);
    check(!ovr && cs_n, "R1", "overrun cleared by reset", ovr, 0);

    for (int fr = 0; fr < 2; fr++) begin
      wait_armed();
      fire(1);
      while (!cs_n) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule